// File: doc/BRIEF.md
# Segment Display Backplane and Phase Driver

This block generates the square-wave backplane for a directly driven segment display and derives every segment level from it. An internal divider turns a stream of oscillator tick pulses into a backplane whose period is 2^DIV_LOG2 ticks. An external backplane input can be selected instead. It passes through a two-flop synchronizer first. Each segment is driven in phase with the backplane when it is dark and in antiphase when it is lit.

A two-bit test-mode input overrides the latched segment data. It can blank every segment, light every segment, or light alternate segments, which helps find opens and shorts on a display. An activity monitor counts system clock cycles between backplane transitions. If the backplane stalls for a full window, the monitor blanks all segments, and this blanking overrides every test mode. Within the full system, the window is set to one period at the lowest acceptable backplane frequency.

Top module: `lcd_bp_seg_drv`

## Requirements
- R1: While the reset is asserted, and after its synchronous release, the divider, synchronizer and monitor start from zero. bp_out is low, and with test_mode 2'b00 the segment outputs equal seg_data.
- R2: With bp_sel low, bp_out is high for 2^(DIV_LOG2-1) osc_tick pulses and then low for the same number of pulses. Clock cycles without a tick leave it unchanged.
- R3: With bp_sel high, bp_out equals bp_ext delayed by two clock cycles.
- R4: test_mode 2'b00: seg_out[i] = bp_out XOR seg_data[i].
- R5: test_mode 2'b01: every seg_out bit equals bp_out, and seg_data has no effect.
- R6: test_mode 2'b10: every seg_out bit is the inverse of bp_out.
- R7: test_mode 2'b11: segment n (bit n-1) is lit, meaning the inverse of bp_out, when n is odd. It equals bp_out when n is even.
- R8: After WIN_CYCLES consecutive clock cycles with no change on bp_out, a fault is raised. While the fault is set, every seg_out bit equals bp_out, whatever test_mode and seg_data are.
- R9: A fault clears only at the second bp_out transition after the fault, and only if no full window has elapsed between those two transitions. A window that expires cancels the first transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, also the monitor timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bp_ext | input | 1 | Externally driven backplane, asynchronous |
| bp_sel | input | 1 | 1 selects bp_ext, 0 selects the internal divider |
| seg_data | input | NSEG | Latched segment data, 1 = lit |
| test_mode | input | 2 | Test pattern code |
| bp_out | output | 1 | Backplane drive level |
| seg_out | output | NSEG | Segment drive levels |

## Verification
The assertions assume that osc_tick pulses are synchronous to clk. They also assume that test_mode and seg_data are static inputs that change only between clock edges. The alternating-pattern and blank checks further assume that bp_sel does not toggle while a fault is being cleared. The stimulus changes every input shortly after a rising edge. It holds test_mode and bp_sel over long stretches. It stalls the backplane by withholding ticks or by freezing bp_ext, and it spaces external edges either well inside or well outside the window.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;
  typedef enum logic [1:0] {
    TM_NORMAL  = 2'b00,
    TM_BLANK   = 2'b01,
    TM_FILL    = 2'b10,
    TM_CHECKER = 2'b11
  } seg_test_e;
endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic bp_int
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bp_int = cnt_q[DIV_LOG2-1];

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bp_int));
endmodule

// File: rtl/lcd_bp_src_sel.sv
module lcd_bp_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_int,
  input  logic bp_ext,
  input  logic bp_sel,
  output logic bp_src
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= bp_ext;
      s2_q <= s1_q;
    end
  end

  assign bp_src = bp_sel ? s2_q : bp_int;
endmodule

// File: rtl/lcd_bp_activity_mon.sv
module lcd_bp_activity_mon #(
  parameter int WIN_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp,
  output logic fault
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d, armed_q, armed_d;
  logic          edge_seen;

  assign edge_seen = (bp != prev_q);

  always_comb begin
    cnt_d   = cnt_q;
    fault_d = fault_q;
    armed_d = armed_q;
    if (edge_seen) begin
      cnt_d = '0;
      if (fault_q) begin
        if (armed_q) begin
          fault_d = 1'b0;
          armed_d = 1'b0;
        end else begin
          armed_d = 1'b1;
        end
      end
    end else if (cnt_q == LAST) begin
      fault_d = 1'b1;
      armed_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= bp;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
      armed_q <= armed_d;
    end
  end

  assign fault = fault_q;

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(cnt_q) == LAST);
  // R9
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(armed_q));
endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase #(
  parameter int NSEG = 80
) (
  input  logic                    bp,
  input  logic                    blank,
  input  lcd_bp_pkg::seg_test_e   mode,
  input  logic [NSEG-1:0]         data,
  output logic [NSEG-1:0]         seg
);
  import lcd_bp_pkg::*;

  logic [NSEG-1:0] alt, lit;

  for (genvar i = 0; i < NSEG; i++) begin : g_alt
    assign alt[i] = ((i % 2) == 0);
  end

  always_comb begin
    unique case (mode)
      TM_NORMAL:  lit = data;
      TM_BLANK:   lit = '0;
      TM_FILL:    lit = '1;
      TM_CHECKER: lit = alt;
      default:    lit = '0;
    endcase
    if (blank) lit = '0;
  end

  assign seg = {NSEG{bp}} ^ lit;
endmodule

// File: rtl/lcd_bp_seg_drv.sv
module lcd_bp_seg_drv #(
  parameter int NSEG       = 80,
  parameter int DIV_LOG2   = 8,
  parameter int WIN_CYCLES = 100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic            bp_ext,
  input  logic            bp_sel,
  input  logic [NSEG-1:0] seg_data,
  input  logic [1:0]      test_mode,
  output logic            bp_out,
  output logic [NSEG-1:0] seg_out
);
  import lcd_bp_pkg::*;

  logic rs1_q, rs2_q, rst_i_n;
  logic bp_int, bp_src, fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  lcd_bp_divider #(.DIV_LOG2(DIV_LOG2)) div_i (
    .clk(clk), .rst_n(rst_i_n), .tick(osc_tick), .bp_int(bp_int));

  lcd_bp_src_sel sel_i (
    .clk(clk), .rst_n(rst_i_n), .bp_int(bp_int), .bp_ext(bp_ext),
    .bp_sel(bp_sel), .bp_src(bp_src));

  lcd_bp_activity_mon #(.WIN_CYCLES(WIN_CYCLES)) mon_i (
    .clk(clk), .rst_n(rst_i_n), .bp(bp_src), .fault(fault));

  lcd_seg_phase #(.NSEG(NSEG)) phase_i (
    .bp(bp_src), .blank(fault), .mode(seg_test_e'(test_mode)),
    .data(seg_data), .seg(seg_out));

  assign bp_out = bp_src;

  // R8
  blank_follows_bp_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fault |-> seg_out == {NSEG{bp_out}});
  // R5
  mode_blank_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    test_mode == 2'b01 |-> seg_out == {NSEG{bp_out}});
  // R6
  mode_fill_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (test_mode == 2'b10 && !fault) |-> seg_out == ~{NSEG{bp_out}});
endmodule

// File: tb/lcd_bp_seg_drv_tb_top.sv
module lcd_bp_seg_drv_tb_top;
  localparam int NSEG = 80;
  localparam int DIVL = 8;
  localparam int WIN  = 2000;
  localparam int HALF = 1 << (DIVL - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, bp_ext = 1'b0, bp_sel = 1'b0;
  logic [NSEG-1:0] seg_data = '0;
  logic [1:0] test_mode = 2'b00;
  logic bp_out;
  logic [NSEG-1:0] seg_out;

  int n_cmp = 0, n_bad = 0;
  int tick_gap = 1;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit r1, r2, s1, s2, prev, fault, armed;
  int ticks, wcnt;

  lcd_bp_seg_drv #(.NSEG(NSEG), .DIV_LOG2(DIVL), .WIN_CYCLES(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bp_ext(bp_ext),
    .bp_sel(bp_sel), .seg_data(seg_data), .test_mode(test_mode),
    .bp_out(bp_out), .seg_out(seg_out));

  always #5 clk = ~clk;

  function automatic bit exp_bp();
    return bp_sel ? s2 : (ticks >= HALF);
  endfunction

  function automatic logic [NSEG-1:0] exp_seg();
    logic [NSEG-1:0] lit;
    case (test_mode)
      2'b00: lit = seg_data;
      2'b01: lit = '0;
      2'b10: lit = '1;
      default: for (int i = 0; i < NSEG; i++) lit[i] = ((i + 1) % 2 == 1);
    endcase
    if (fault) lit = '0;
    return {NSEG{exp_bp()}} ^ lit;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0; s1 = 0; s2 = 0; prev = 0; fault = 0; armed = 0;
      ticks = 0; wcnt = 0;
    end else begin
      if (r2) begin
        bit b;
        b = exp_bp();
        if (b != prev) begin
          wcnt = 0;
          if (fault) begin
            if (armed) begin fault = 0; armed = 0; end
            else armed = 1;
          end
        end else if (wcnt == WIN - 1) begin
          fault = 1; armed = 0;
        end else wcnt++;
        prev = b;
        if (osc_tick) ticks = (ticks + 1) % (2 * HALF);
        s2 = s1; s1 = bp_ext;
      end
      r2 = r1; r1 = 1;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (bp_out !== exp_bp()) begin
        n_bad++;
        $display("FAIL %s bp_out actual=%b expected=%b at cycle %0d",
                 bp_sel ? "R3" : "R2", bp_out, exp_bp(), cyc);
      end
      n_cmp++;
      if (seg_out !== exp_seg()) begin
        n_bad++;
        $display("FAIL %s seg_out actual=%h expected=%h at cycle %0d",
                 fault ? "R8" : (test_mode == 2'b00 ? "R4" : test_mode == 2'b01 ? "R5" :
                 test_mode == 2'b10 ? "R6" : "R7"), seg_out, exp_seg(), cyc);
      end
    end
  end

  // tick generator and external backplane toggler
  int ext_half = 0;
  int ext_cnt = 0;
  always @(posedge clk) begin
    cyc++;
    #2;
    if (tick_gap == 0) osc_tick = 0;
    else osc_tick = (cyc % tick_gap) == 0;
    if (ext_half != 0) begin
      ext_cnt++;
      if (ext_cnt >= ext_half) begin ext_cnt = 0; bp_ext = ~bp_ext; end
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(bit ok, string req, string what, logic [NSEG-1:0] act,
                       logic [NSEG-1:0] expv);
    @(negedge clk); #1;
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  initial begin
    seg_data = {NSEG/4{4'b1011}};
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    n_cmp++;
    if (bp_out !== 1'b0 || seg_out !== seg_data) begin
      n_bad++;
      $display("FAIL R1 reset state actual=%b/%h expected=0/%h", bp_out, seg_out, seg_data);
    end
    run(600);                                        // R2, R4
    seg_data = {NSEG/8{8'h3C}};
    tick_gap = 3; run(1200);                         // R2 slower ticks
    tick_gap = 1;
    test_mode = 2'b01; seg_data = '1; run(400);      // R5
    test_mode = 2'b10; run(400);                     // R6
    test_mode = 2'b11; run(400);                     // R7
    // stall the internal backplane: R8
    test_mode = 2'b10; tick_gap = 0; run(WIN + 300);
    check(seg_out == {NSEG{bp_out}}, "R8", "blank on stall", seg_out, {NSEG{bp_out}});
    // recover: R9
    tick_gap = 1; run(3 * HALF + 20);
    check(seg_out == ~{NSEG{bp_out}}, "R9", "recovered fill", seg_out, ~{NSEG{bp_out}});
    // external backplane: R3
    bp_sel = 1'b1; ext_half = 50; test_mode = 2'b11; run(500);
    test_mode = 2'b00; seg_data = {NSEG/4{4'h6}}; run(500);
    // freeze external: R8
    ext_half = 0; run(WIN + 200);
    check(seg_out == {NSEG{bp_out}}, "R8", "blank on frozen ext", seg_out, {NSEG{bp_out}});
    // slow edges beyond window keep the fault: R9
    ext_half = WIN + 300; run(3 * (WIN + 300));
    check(seg_out == {NSEG{bp_out}}, "R9", "slow edges keep blank", seg_out, {NSEG{bp_out}});
    ext_half = 40; ext_cnt = 0; run(300);
    check(seg_out == ({NSEG{bp_out}} ^ seg_data), "R9", "fast edges clear", seg_out,
          {NSEG{bp_out}} ^ seg_data);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    done = 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule